// File: doc/BRIEF.md
# Rotating Priority Shared Memory Arbiter

This block decides which of four processor ports may use a single shared memory. Every port raises a request line. When the memory is free, the arbiter picks one requester. It raises that port's grant bit and presents the port's 2-bit number. The grant stays in place until the granted port reports that its access has finished.

Fairness comes from a rotation counter. Before a fixed priority encoder sees the request vector, a barrel shifter rotates the vector by the counter value. The counter is then added back, modulo the port count, to the encoder's index, so the result names the real port. The counter steps once per completed access, so the top-priority slot moves round the ports and each port gets a roughly even share.

Handshake rules: a request acts as a valid and the grant acts as its ready. A port keeps its request high until its grant appears. The arbiter never drops a grant on its own. `done_i` is the completion strobe from the granted port. After a completion the grant drops for one cycle, and arbitration starts again on the cycle that follows.

Top module: `rr_rotate_arbiter`

## Requirements
- R1: After reset `busy_o` is 0, `gnt_o` is 0, `gnt_id_o` is 0 and the rotation counter is 0. With the counter at 0, port 0 has the highest priority.
- R2: While the arbiter is idle and no request is high, no grant is issued and the rotation counter keeps its value.
- R3: When the arbiter is idle and at least one request is high at a clock edge, `busy_o` is 1 after that edge. `gnt_o` then has exactly one bit set, bit i for port i, and `gnt_id_o` holds i as an unsigned binary number.
- R4: The winner is the first requesting port met when scanning the port numbers c, c+1, c+2, c+3 modulo 4, where c is the rotation counter.
- R5: While busy, the grant and `gnt_id_o` hold steady until `done_i` is high on the bit of the granted port. Request changes and `done_i` bits of other ports have no effect during that time.
- R6: A completion at an edge clears `busy_o` and `gnt_o` after that edge and adds 1, modulo 4, to the rotation counter. If requests are still high, a new grant appears one edge later.
- R7: With all four ports requesting continuously, the grants run through ports 0, 1, 2, 3 and repeat, so no port is starved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request per port, held until granted |
| done_i | input | 4 | Access-complete strobe per port; only the granted port's bit counts |
| gnt_o | output | 4 | One-hot grant, bit i for port i |
| gnt_id_o | output | 2 | Binary number of the granted port |
| busy_o | output | 1 | Memory currently granted to a port |

## Verification
A wrong rotation count, or a rotate and an add that run in the same direction instead of opposite ones, shows up as a wrong `gnt_id_o`. This appears on the first grant after the fault, once more than one port is requesting. The bench therefore sweeps all fifteen non-empty request patterns against all four counter values and compares every winner with the scan rule. A hold or release fault, such as honouring another port's completion or missing a counter step, shows within one cycle of that completion, either in `busy_o` or in the next winner.

// File: rtl/arb_rot_pkg.sv
package arb_rot_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  function automatic int mod_wrap(input int value, input int modulus);
    return value % modulus;
  endfunction
endpackage

// File: rtl/arb_rot_shift.sv
module arb_rot_shift #(
  parameter int NUM_PORTS = 4,
  parameter int IDW       = 2
) (
  input  logic [NUM_PORTS-1:0] vec_i,
  input  logic [IDW-1:0]       amt_i,
  output logic [NUM_PORTS-1:0] rot_o
);
  // Rotate right: output slot k looks at port (k + amt)
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_slot
    always_comb begin
      rot_o[k] = vec_i[arb_rot_pkg::mod_wrap(k + int'(amt_i), NUM_PORTS)];
    end
  end
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
  parameter int NUM_PORTS = 4,
  parameter int IDW       = 2
) (
  input  logic [NUM_PORTS-1:0] vec_i,
  output logic [IDW-1:0]       idx_o,
  output logic                 any_o
);
  // Lowest set slot wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        idx_o = IDW'(k);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_mod_add.sv
module arb_mod_add #(
  parameter int NUM_PORTS = 4,
  parameter int IDW       = 2
) (
  input  logic [IDW-1:0] a_i,
  input  logic [IDW-1:0] b_i,
  output logic [IDW-1:0] sum_o
);
  always_comb begin
    sum_o = IDW'(arb_rot_pkg::mod_wrap(int'(a_i) + int'(b_i), NUM_PORTS));
  end
endmodule

// File: rtl/rr_rotate_arbiter.sv
module rr_rotate_arbiter #(
  parameter int NUM_PORTS = 4,
  localparam int IDW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [NUM_PORTS-1:0] done_i,
  output logic [NUM_PORTS-1:0] gnt_o,
  output logic [IDW-1:0]       gnt_id_o,
  output logic                 busy_o
);
  import arb_rot_pkg::*;

  arb_state_e           state_q;
  logic [IDW-1:0]       cnt_q;
  logic [IDW-1:0]       id_q;
  logic [NUM_PORTS-1:0] rot_req;
  logic [IDW-1:0]       enc_idx;
  logic                 enc_any;
  logic [IDW-1:0]       winner;
  logic [IDW-1:0]       cnt_next;
  logic                 complete;

  arb_rot_shift #(.NUM_PORTS(NUM_PORTS), .IDW(IDW)) u_shift (
    .vec_i (req_i),
    .amt_i (cnt_q),
    .rot_o (rot_req)
  );

  arb_prio_enc #(.NUM_PORTS(NUM_PORTS), .IDW(IDW)) u_enc (
    .vec_i (rot_req),
    .idx_o (enc_idx),
    .any_o (enc_any)
  );

  // Add the rotation back so the index names the real port
  arb_mod_add #(.NUM_PORTS(NUM_PORTS), .IDW(IDW)) u_fix (
    .a_i   (enc_idx),
    .b_i   (cnt_q),
    .sum_o (winner)
  );

  arb_mod_add #(.NUM_PORTS(NUM_PORTS), .IDW(IDW)) u_step (
    .a_i   (cnt_q),
    .b_i   (IDW'(1)),
    .sum_o (cnt_next)
  );

  assign complete = (state_q == ARB_BUSY) && done_i[id_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      cnt_q   <= '0;
      id_q    <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (enc_any) begin
            state_q <= ARB_BUSY;
            id_q    <= winner;
          end
        end
        ARB_BUSY: begin
          if (complete) begin
            state_q <= ARB_IDLE;
            cnt_q   <= cnt_next;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gnt
    assign gnt_o[p] = (state_q == ARB_BUSY) && (id_q == IDW'(p));
  end

  assign gnt_id_o = id_q;
  assign busy_o   = (state_q == ARB_BUSY);
endmodule

// File: rtl/arb_rot_checker.sv
module arb_rot_checker #(
  parameter int NUM_PORTS = 4,
  parameter int IDW       = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req_i,
  input logic [NUM_PORTS-1:0] done_i,
  input logic [NUM_PORTS-1:0] gnt_o,
  input logic [IDW-1:0]       gnt_id_o,
  input logic                 busy_o,
  input logic [IDW-1:0]       cnt
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R3

  AST_GNT_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> gnt_o[gnt_id_o]); // R3

  AST_GNT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (|($past(req_i) & gnt_o))); // R4

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (req_i == '0)) |=> !busy_o); // R2

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i[gnt_id_o]) |=> (busy_o && $stable(gnt_id_o))); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i[gnt_id_o]) |=> !busy_o); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i[gnt_id_o]) |=>
      (int'(cnt) == (int'($past(cnt)) + 1) % NUM_PORTS)); // R6

  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_i[gnt_id_o]) |=> $stable(cnt)); // R2
endmodule

bind rr_rotate_arbiter arb_rot_checker #(.NUM_PORTS(NUM_PORTS), .IDW(IDW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .done_i   (done_i),
  .gnt_o    (gnt_o),
  .gnt_id_o (gnt_id_o),
  .busy_o   (busy_o),
  .cnt      (cnt_q)
);

// File: tb/tb_rr_rotate_arbiter.sv
module tb_rr_rotate_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int Q = CLK_PERIOD / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] done = '0;
  logic [NP-1:0] gnt;
  logic [1:0]    gnt_id;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  rr_rotate_arbiter #(.NUM_PORTS(NP)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .done_i   (done),
    .gnt_o    (gnt),
    .gnt_id_o (gnt_id),
    .busy_o   (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [NP-1:0] r, input int c);
    for (int k = 0; k < NP; k++) begin
      if (r[(c + k) % NP]) return (c + k) % NP;
    end
    return -1;
  endfunction

  // One full access: request, grant, ignored noise, completion
  task automatic do_access(input logic [NP-1:0] pat);
    int w;
    w = pick(pat, exp_cnt);
    @(negedge clk); req = pat; done = '0;
    @(posedge clk); #Q;
    check("R3 busy after request", int'(busy), 1);
    check("R4 winner id", int'(gnt_id), w);
    check("R3 one-hot grant", int'(gnt), 1 << w);
    @(negedge clk); done = ~(NP'(1) << w); req = ~pat;
    @(posedge clk); #Q;
    check("R5 held busy", int'(busy), 1);
    check("R5 held id", int'(gnt_id), w);
    @(negedge clk); done = NP'(1) << w; req = '0;
    @(posedge clk); #Q;
    check("R6 release busy", int'(busy), 0);
    check("R6 release gnt", int'(gnt), 0);
    exp_cnt = (exp_cnt + 1) % NP;
    @(negedge clk); done = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #Q;
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset gnt", int'(gnt), 0);
    check("R1 reset id", int'(gnt_id), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: idle with no requests, stray done strobes
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); done = 4'hF;
      @(posedge clk); #Q;
      check("R2 no grant without request", int'(busy), 0);
    end
    @(negedge clk); done = '0;

    // R1 + R4: first access with all ports must go to port 0
    do_access(4'hF);

    // R4: every pattern against every counter value (15 and 4 coprime)
    for (int round = 0; round < NP; round++) begin
      for (int p = 1; p < 16; p++) begin
        do_access(NP'(p));
      end
    end

    // R2: idle gap must not move the counter
    repeat (4) @(posedge clk);
    do_access(4'hF);

    // R7 + R6: continuous requests from all ports
    @(negedge clk); req = 4'hF;
    @(posedge clk); #Q;
    for (int i = 0; i < 12; i++) begin
      check("R7 rotation busy", int'(busy), 1);
      check("R7 rotation id", int'(gnt_id), exp_cnt);
      @(negedge clk); done = gnt;
      @(posedge clk); #Q;
      check("R6 gap after completion", int'(busy), 0);
      exp_cnt = (exp_cnt + 1) % NP;
      @(negedge clk); done = '0;
      @(posedge clk); #Q;
      check("R6 resume next cycle", int'(busy), 1);
    end
    @(negedge clk); req = '0;

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule